// File: doc/BRIEF.md
# DRAM Power-Up Command Sequencer

This block walks a DDR1 or DDR2 memory device through its power-up command sequence once reset is released and a start pulse arrives. A strap input, captured on that start pulse, picks which of the two sequences runs. Each command goes out as a one-cycle pulse on a one-hot strobe vector. A mode-register value output carries the word that belongs to each load command. After every command the block waits a programmable number of clock cycles before it issues the next one.

When the final step and its wait have finished, the block produces a refresh control word. This word has the periodic-refresh enable set and a fixed refresh interval. The block also raises a done flag, which stays high until the next reset. The timing registers, the PHY and the DRAM pins sit outside this block. It only produces the command/value stream and the refresh word.

Top module: `dram_init_seq`

## Requirements
- R1: After reset, `cmd_o`, `mode_val_o`, `refresh_ctl_o` and `done_o` are all zero, and they stay zero until `start_i` is seen high.
- R2: `cmd_o` has at most one bit set. Each command is a single-cycle pulse. The bit meanings are: bit0 mode-register load, bit1 extended-mode-1 load, bit2 auto-refresh, bit3 precharge-all, bit4 extended-mode-2 load, bit5 extended-mode-3 load.
- R3: With the strap low (DDR1), the commands run in this order: precharge-all; extended-mode-1 load of 0x000; mode load of 0x133; precharge-all; auto-refresh; auto-refresh; mode load of 0x033.
- R4: With the strap high (DDR2), the block first issues a short preamble of an extended-mode-2 load and then an extended-mode-3 load. It then runs: precharge-all; extended-mode-2 load; extended-mode-3 load; extended-mode-1 load of 0x402; mode load of 0x143; precharge-all; auto-refresh; auto-refresh; mode load of 0x043; extended-mode-1 load of 0x782; extended-mode-1 load of 0x402.
- R5: `mode_val_o` equals the step's value in the cycle of its strobe. That value is 0x000 for precharge-all, auto-refresh and the extended-mode-2/3 loads.
- R6: After each strobe, exactly `LONG_WAIT` strobe-free cycles pass before the next strobe, or before done for the last step. The only exception is R7.
- R7: The two DDR2 preamble steps are each followed by exactly `SHORT_WAIT` strobe-free cycles.
- R8: When the last wait elapses, `done_o` rises and `refresh_ctl_o` becomes enable (bit 14) plus interval 312 in bits 9:0, which is 0x4138. Before that point `refresh_ctl_o` is zero.
- R9: Once done, `done_o` and `refresh_ctl_o` hold until reset, and no further strobes are issued, even if `start_i` pulses again.
- R10: The strap is sampled only on the accepted start. A later change of `ddr2_sel_i`, or a start pulse while the sequence is running, has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launches the sequence from idle |
| ddr2_sel_i | input | 1 | Strap: 1 selects the DDR2 sequence, 0 selects DDR1 |
| cmd_o | output | 6 | One-hot command strobe |
| mode_val_o | output | 13 | Mode-register word for the current load command |
| refresh_ctl_o | output | 15 | Refresh control word: enable bit 14, interval in bits 9:0 |
| done_o | output | 1 | Sequence complete; sticky until reset |

## Verification
The bench targets several corner cases, each with a distinct failure it would expose:
- The switch from the short DDR2 preamble waits to the long waits. A design that applied the wrong length would shift every later strobe by a fixed offset.
- The spacing between the last strobe and the rise of done. An off-by-one counter shows up here as a gap of 99 or 101 cycles.
- A strap change and a second start pulse in the middle of a DDR2 run. A design that re-sampled the strap or restarted would emit DDR1 commands or repeat the preamble.
- A start pulse after done. A design without a sticky final state would replay the sequence or drop the refresh enable.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

    localparam int CMD_W   = 6;
    localparam int MODE_W  = 13;
    localparam int STEP_W  = 4;

    // strobe bit positions (fixed encoding seen by the command path)
    localparam int CB_MR   = 0;
    localparam int CB_EMR1 = 1;
    localparam int CB_AREF = 2;
    localparam int CB_PREA = 3;
    localparam int CB_EMR2 = 4;
    localparam int CB_EMR3 = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [MODE_W-1:0] val;
        logic              short_wait;
        logic              last;
    } step_t;

endpackage

// File: rtl/dram_step_table.sv
module dram_step_table
    import dram_init_pkg::*;
(
    input  logic              ddr2_i,
    input  logic [STEP_W-1:0] idx_i,
    output step_t             step_o
);

    function automatic step_t mk(input int bit_pos, input logic [MODE_W-1:0] v,
                                 input logic sw, input logic lst);
        step_t s;
        s.cmd        = '0;
        s.cmd[bit_pos] = 1'b1;
        s.val        = v;
        s.short_wait = sw;
        s.last       = lst;
        return s;
    endfunction

    step_t ddr1_step;
    step_t ddr2_step;

    always_comb begin
        case (idx_i)
            4'd0:    ddr1_step = mk(CB_PREA, 13'h000, 1'b0, 1'b0);
            4'd1:    ddr1_step = mk(CB_EMR1, 13'h000, 1'b0, 1'b0);
            4'd2:    ddr1_step = mk(CB_MR,   13'h133, 1'b0, 1'b0);
            4'd3:    ddr1_step = mk(CB_PREA, 13'h000, 1'b0, 1'b0);
            4'd4:    ddr1_step = mk(CB_AREF, 13'h000, 1'b0, 1'b0);
            4'd5:    ddr1_step = mk(CB_AREF, 13'h000, 1'b0, 1'b0);
            default: ddr1_step = mk(CB_MR,   13'h033, 1'b0, 1'b1);
        endcase
    end

    always_comb begin
        case (idx_i)
            4'd0:    ddr2_step = mk(CB_EMR2, 13'h000, 1'b1, 1'b0);
            4'd1:    ddr2_step = mk(CB_EMR3, 13'h000, 1'b1, 1'b0);
            4'd2:    ddr2_step = mk(CB_PREA, 13'h000, 1'b0, 1'b0);
            4'd3:    ddr2_step = mk(CB_EMR2, 13'h000, 1'b0, 1'b0);
            4'd4:    ddr2_step = mk(CB_EMR3, 13'h000, 1'b0, 1'b0);
            4'd5:    ddr2_step = mk(CB_EMR1, 13'h402, 1'b0, 1'b0);
            4'd6:    ddr2_step = mk(CB_MR,   13'h143, 1'b0, 1'b0);
            4'd7:    ddr2_step = mk(CB_PREA, 13'h000, 1'b0, 1'b0);
            4'd8:    ddr2_step = mk(CB_AREF, 13'h000, 1'b0, 1'b0);
            4'd9:    ddr2_step = mk(CB_AREF, 13'h000, 1'b0, 1'b0);
            4'd10:   ddr2_step = mk(CB_MR,   13'h043, 1'b0, 1'b0);
            4'd11:   ddr2_step = mk(CB_EMR1, 13'h782, 1'b0, 1'b0);
            default: ddr2_step = mk(CB_EMR1, 13'h402, 1'b0, 1'b1);
        endcase
    end

    assign step_o = ddr2_i ? ddr2_step : ddr1_step;

endmodule

// File: rtl/dram_wait_timer.sv
module dram_wait_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
    import dram_init_pkg::*;
#(
    parameter int LONG_WAIT    = 100,
    parameter int SHORT_WAIT   = 10,
    parameter int REF_INTERVAL = 312,
    parameter int REF_FIELD_W  = 10,
    parameter int REF_EN_BIT   = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  ddr2_sel_i,
    output logic [CMD_W-1:0]      cmd_o,
    output logic [MODE_W-1:0]     mode_val_o,
    output logic [REF_EN_BIT:0]   refresh_ctl_o,
    output logic                  done_o
);

    localparam int REF_W = REF_EN_BIT + 1;
    localparam int CNT_W = $clog2(LONG_WAIT + 1);
    localparam logic [CNT_W-1:0]       LONG_LD  = CNT_W'(LONG_WAIT - 1);
    localparam logic [CNT_W-1:0]       SHORT_LD = CNT_W'(SHORT_WAIT - 1);
    localparam logic [REF_FIELD_W-1:0] REF_VAL  = REF_FIELD_W'(REF_INTERVAL);

    typedef struct packed {
        seq_state_e        st;
        logic              ddr2;
        logic [STEP_W-1:0] idx;
        logic              last;
        logic [CMD_W-1:0]  cmd;
        logic [MODE_W-1:0] val;
        logic [REF_W-1:0]  refw;
        logic              done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    step_t            cur_step;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    dram_step_table u_table (
        .ddr2_i (r_q.ddr2),
        .idx_i  (r_q.idx),
        .step_o (cur_step)
    );

    dram_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    always_comb begin
        r_d      = r_q;
        r_d.cmd  = '0;
        tmr_load = 1'b0;
        tmr_val  = LONG_LD;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.ddr2 = ddr2_sel_i;
                    r_d.idx  = '0;
                    r_d.st   = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                r_d.cmd  = cur_step.cmd;
                r_d.val  = cur_step.val;
                r_d.last = cur_step.last;
                tmr_load = 1'b1;
                tmr_val  = cur_step.short_wait ? SHORT_LD : LONG_LD;
                r_d.st   = ST_WAIT;
            end
            ST_WAIT: begin
                if (tmr_zero) begin
                    if (r_q.last) begin
                        r_d.st   = ST_DONE;
                        r_d.done = 1'b1;
                        r_d.refw = '0;
                        r_d.refw[REF_EN_BIT] = 1'b1;
                        r_d.refw[REF_FIELD_W-1:0] = REF_VAL;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                        r_d.st  = ST_ISSUE;
                    end
                end
            end
            default: begin
                r_d.st = ST_DONE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, ddr2: 1'b0, idx: '0, last: 1'b0,
                     cmd: '0, val: '0, refw: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_o         = r_q.cmd;
    assign mode_val_o    = r_q.val;
    assign refresh_ctl_o = r_q.refw;
    assign done_o        = r_q.done;

endmodule

// File: rtl/dram_init_seq_chk.sv
module dram_init_seq_chk #(
    parameter int CMD_W      = 6,
    parameter int REF_EN_BIT = 14,
    parameter int LONG_WAIT  = 100,
    parameter int SHORT_WAIT = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic [CMD_W-1:0]    cmd_o,
    input logic [REF_EN_BIT:0] refresh_ctl_o,
    input logic                done_o
);

    localparam int GAP_W = $clog2(LONG_WAIT + 2) + 1;
    localparam logic [GAP_W-1:0] GAP_MAX = '1;

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (cmd_o != '0) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != GAP_MAX) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_o));

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o != '0) |=> (cmd_o == '0));

    a_r6_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o != '0) && seen_q) |->
            (gap_q == GAP_W'(LONG_WAIT) || gap_q == GAP_W'(SHORT_WAIT)));

    a_r8_refresh_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (refresh_ctl_o == '0));

    a_r8_refresh_on: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> refresh_ctl_o[REF_EN_BIT]);

    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (done_o && $stable(refresh_ctl_o)));

    a_r9_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cmd_o == '0));

endmodule

bind dram_init_seq dram_init_seq_chk #(
    .CMD_W      (dram_init_pkg::CMD_W),
    .REF_EN_BIT (REF_EN_BIT),
    .LONG_WAIT  (LONG_WAIT),
    .SHORT_WAIT (SHORT_WAIT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_o         (cmd_o),
    .refresh_ctl_o (refresh_ctl_o),
    .done_o        (done_o)
);

// File: tb/dram_init_seq_bench.sv
module dram_init_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LW = 100;
    localparam int SW = 10;

    localparam logic [5:0] C_MR   = 6'b000001;
    localparam logic [5:0] C_EMR1 = 6'b000010;
    localparam logic [5:0] C_AREF = 6'b000100;
    localparam logic [5:0] C_PREA = 6'b001000;
    localparam logic [5:0] C_EMR2 = 6'b010000;
    localparam logic [5:0] C_EMR3 = 6'b100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        ddr2_sel_i = 1'b0;
    logic [5:0]  cmd_o;
    logic [12:0] mode_val_o;
    logic [14:0] refresh_ctl_o;
    logic        done_o;

    int n_chk = 0;
    int n_fail = 0;

    dram_init_seq u_dram_init_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .ddr2_sel_i    (ddr2_sel_i),
        .cmd_o         (cmd_o),
        .mode_val_o    (mode_val_o),
        .refresh_ctl_o (refresh_ctl_o),
        .done_o        (done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // capture of strobes, sampled away from the active edge
    int          cyc = 0;
    int          cap_n = 0;
    logic [5:0]  cap_cmd [32];
    logic [12:0] cap_val [32];
    int          cap_cyc [32];
    int          done_cyc = -1;
    logic        done_prev = 1'b0;
    logic [5:0]  cmd_prev = '0;
    int          bad_onehot = 0;
    int          bad_pulse = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (cmd_o != '0) begin
            if (cap_n < 32) begin
                cap_cmd[cap_n] = cmd_o;
                cap_val[cap_n] = mode_val_o;
                cap_cyc[cap_n] = cyc;
            end
            cap_n = cap_n + 1;
            if (!$onehot(cmd_o)) bad_onehot = bad_onehot + 1;
            if (cmd_prev != '0) bad_pulse = bad_pulse + 1;
        end
        if (done_o && !done_prev) done_cyc = cyc;
        done_prev = done_o;
        cmd_prev  = cmd_o;
    end

    // expected sequence built from the requirements
    logic [5:0]  exp_cmd [16];
    logic [12:0] exp_val [16];
    int          exp_wait [16];
    int          exp_n;

    task automatic add_step(input logic [5:0] c, input logic [12:0] v, input int w);
        exp_cmd[exp_n]  = c;
        exp_val[exp_n]  = v;
        exp_wait[exp_n] = w;
        exp_n = exp_n + 1;
    endtask

    task automatic build_ddr1();
        exp_n = 0;
        add_step(C_PREA, 13'h000, LW);
        add_step(C_EMR1, 13'h000, LW);
        add_step(C_MR,   13'h133, LW);
        add_step(C_PREA, 13'h000, LW);
        add_step(C_AREF, 13'h000, LW);
        add_step(C_AREF, 13'h000, LW);
        add_step(C_MR,   13'h033, LW);
    endtask

    task automatic build_ddr2();
        exp_n = 0;
        add_step(C_EMR2, 13'h000, SW);
        add_step(C_EMR3, 13'h000, SW);
        add_step(C_PREA, 13'h000, LW);
        add_step(C_EMR2, 13'h000, LW);
        add_step(C_EMR3, 13'h000, LW);
        add_step(C_EMR1, 13'h402, LW);
        add_step(C_MR,   13'h143, LW);
        add_step(C_PREA, 13'h000, LW);
        add_step(C_AREF, 13'h000, LW);
        add_step(C_AREF, 13'h000, LW);
        add_step(C_MR,   13'h043, LW);
        add_step(C_EMR1, 13'h782, LW);
        add_step(C_EMR1, 13'h402, LW);
    endtask

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 4000; i++) begin
            if (done_o) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    // compare captured strobes from index base against the expected list
    task automatic compare_run(input int base, input string req_seq, input string req_wait);
        check(cap_n - base == exp_n, req_seq, "strobe count", cap_n - base, exp_n);
        for (int i = 0; i < exp_n; i++) begin
            if (base + i < 32 && base + i < cap_n) begin
                check(cap_cmd[base+i] == exp_cmd[i], req_seq, $sformatf("cmd of step %0d", i),
                      int'(cap_cmd[base+i]), int'(exp_cmd[i]));
                check(cap_val[base+i] == exp_val[i], "R5", $sformatf("value of step %0d", i),
                      int'(cap_val[base+i]), int'(exp_val[i]));
                if (i > 0)
                    check(cap_cyc[base+i] - cap_cyc[base+i-1] - 1 == exp_wait[i-1],
                          (exp_wait[i-1] == SW) ? "R7" : req_wait,
                          $sformatf("gap before step %0d", i),
                          cap_cyc[base+i] - cap_cyc[base+i-1] - 1, exp_wait[i-1]);
            end
        end
        if (exp_n > 0 && base + exp_n - 1 < 32 && base + exp_n - 1 < cap_n)
            check(done_cyc - cap_cyc[base+exp_n-1] == exp_wait[exp_n-1], "R6",
                  "last strobe to done", done_cyc - cap_cyc[base+exp_n-1], exp_wait[exp_n-1]);
        check(done_o == 1'b1, "R8", "done after run", int'(done_o), 1);
        check(refresh_ctl_o == 15'h4138, "R8", "refresh word", int'(refresh_ctl_o), 'h4138);
    endtask

    task automatic test_reset_idle();
        int base;
        do_reset();
        base = cap_n;
        check(cmd_o == '0, "R1", "cmd after reset", int'(cmd_o), 0);
        check(mode_val_o == '0, "R1", "mode value after reset", int'(mode_val_o), 0);
        check(refresh_ctl_o == '0, "R1", "refresh after reset", int'(refresh_ctl_o), 0);
        check(done_o == 1'b0, "R1", "done after reset", int'(done_o), 0);
        ddr2_sel_i = 1'b1;
        repeat (40) @(negedge clk);
        check(cap_n == base, "R1", "strobes without start", cap_n - base, 0);
        check(done_o == 1'b0, "R1", "done without start", int'(done_o), 0);
    endtask

    task automatic test_ddr1();
        int base;
        ddr2_sel_i = 1'b0;
        build_ddr1();
        base = cap_n;
        pulse_start();
        wait_done();
        compare_run(base, "R3", "R6");
    endtask

    task automatic test_restart_after_done();
        int base;
        base = cap_n;
        ddr2_sel_i = 1'b1;
        pulse_start();
        repeat (300) @(negedge clk);
        check(cap_n == base, "R9", "strobes after done", cap_n - base, 0);
        check(done_o == 1'b1, "R9", "done held", int'(done_o), 1);
        check(refresh_ctl_o == 15'h4138, "R9", "refresh held", int'(refresh_ctl_o), 'h4138);
    endtask

    task automatic test_ddr2_disturbed();
        int base;
        do_reset();
        ddr2_sel_i = 1'b1;
        build_ddr2();
        base = cap_n;
        pulse_start();
        repeat (60) @(negedge clk);
        check(refresh_ctl_o == '0, "R8", "refresh before done", int'(refresh_ctl_o), 0);
        check(done_o == 1'b0, "R8", "done before end", int'(done_o), 0);
        // strap flip and a second start while running must not matter
        ddr2_sel_i = 1'b0;
        pulse_start();
        repeat (250) @(negedge clk);
        pulse_start();
        wait_done();
        check(bad_onehot == 0, "R2", "non-one-hot strobes", bad_onehot, 0);
        check(bad_pulse == 0, "R2", "multi-cycle strobes", bad_pulse, 0);
        compare_run(base, "R4", "R6");
        check(cap_n - base == 13, "R10", "strap change ignored", cap_n - base, 13);
    endtask

    initial begin
        fork
            begin
                test_reset_idle();
                test_ddr1();
                test_restart_after_done();
                test_ddr2_disturbed();
            end
            begin
                repeat (200000) @(negedge clk);
                n_chk = n_chk + 1;
                n_fail = n_fail + 1;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule